// File: doc/BRIEF.md
# Code Memory Programming, Lock and Verify Controller

This block governs access to a small on-chip code store during device programming. Four mode pins are decoded into one of six operations: writing a code byte, reading a code byte back for verification, writing a byte of a 32-entry scrambling table, setting either of two protection fuses, or reading fixed identification bytes. Writes happen only on a qualified active-low program strobe. Each qualified strobe ANDs the input byte into the target, so repeated strobes can only clear bits. A counter tracks how many qualified strobes have landed in the current programming session, so a quick-pulse algorithm of a fixed number of pulses can be followed.

During verification the addressed code byte is XNORed with the scrambling byte selected by the five low address bits. An erased table is all ones and returns the code unchanged. The first fuse blocks further code and table writes, flags that external fetches must not read the internal store, and freezes the external-access strap at the value it had during reset. Both fuses together also suppress verification. A full erase restores every byte and fuse to ones, which is the unlocked state.

Top module: `code_lock_ctrl`

## Requirements
- R1: The pin vector {sel_wr, sel_tgt, sel_area, sel_aux} selects the mode: 1011 code write, 0011 verify, 1001 table write, 1111 fuse 1, 1100 fuse 2, 0000 identification. Any other vector is idle: vdata reads FF and strobes change nothing.
- R2: In verify mode, vdata one clock later equals ~(code[addr] ^ table[addr[4:0]]), where code is indexed by the low MEM_AW address bits.
- R3: With an erased table, verify returns the stored code byte unmodified.
- R4: A strobe counts only if prog_n was low for at least MIN_LOW clock edges. On its rising end the target byte becomes old AND din. Shorter strobes write nothing.
- R5: pulse_cnt counts qualified strobes in a write mode, saturates at PULSES, and pulse_done is high exactly at PULSES. The count clears on any clock where the mode is not a write mode (code, table, fuse 1 or fuse 2).
- R6: Once fuse 1 is set, fetch_blocked and prog_blocked are high, and code and table writes are ignored.
- R7: Without fuse 1, ext_access_eff follows ext_access_n. With fuse 1 set, it holds the value ext_access_n had during the last reset.
- R8: With both fuses set, verify_blocked is high and verify returns FF. Fuse 2 alone adds no restriction.
- R9: Identification mode returns 89 at address 030h, SIG_ID (default 52) at 031h and FF elsewhere, whatever the fuses.
- R10: erase sets every code and table byte to FF, clears both fuses and the pulse count.
- R11: After reset vdata is FF and pulse_cnt is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; samples the external-access strap |
| erase | input | 1 | Full erase of store, table and fuses |
| sel_wr | input | 1 | Mode pin: write versus read |
| sel_tgt | input | 1 | Mode pin: fuse target |
| sel_area | input | 1 | Mode pin: code versus table area |
| sel_aux | input | 1 | Mode pin: auxiliary select |
| prog_n | input | 1 | Active-low program strobe |
| ext_access_n | input | 1 | External-access strap level |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Byte to program |
| vdata | output | 8 | Registered verify or identification data |
| pulse_cnt | output | CNT_W | Qualified strobes in this session |
| pulse_done | output | 1 | Strobe count has reached PULSES |
| fetch_blocked | output | 1 | External fetches may not read internal store |
| prog_blocked | output | 1 | Code and table writes refused |
| verify_blocked | output | 1 | Verify reads suppressed |
| ext_access_eff | output | 1 | Effective external-access strap |

## Verification
The hardest state to reach is a fuse-1 device whose strap differs from its value at reset. This needs a reset with one strap level, fuse programming, and then a change of the pin. The bench drives that sequence directly and then applies a second reset under the fuse to show that the frozen value is taken again. Random code and table writes with strobe widths around MIN_LOW exercise the qualification edge and the AND accumulation against a bench model, before the fuse sequences run.

// File: rtl/code_lock_ctrl.sv
module code_lock_ctrl #(
  parameter int ADDR_W  = 13,
  parameter int MEM_AW  = 10,
  parameter int ENC_AW  = 5,
  parameter int PULSES  = 25,
  parameter int MIN_LOW = 4,
  parameter int CNT_W   = $clog2(PULSES + 1),
  parameter logic [7:0] SIG_ID = 8'h52
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase,
  input  logic              sel_wr,
  input  logic              sel_tgt,
  input  logic              sel_area,
  input  logic              sel_aux,
  input  logic              prog_n,
  input  logic              ext_access_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        vdata,
  output logic [CNT_W-1:0]  pulse_cnt,
  output logic              pulse_done,
  output logic              fetch_blocked,
  output logic              prog_blocked,
  output logic              verify_blocked,
  output logic              ext_access_eff
);
  localparam int MEM_DEPTH = 1 << MEM_AW;
  localparam int ENC_DEPTH = 1 << ENC_AW;
  localparam int LW        = $clog2(MIN_LOW + 1);

  typedef enum logic [2:0] {M_IDLE, M_CODE, M_VER, M_ENC, M_FUSE1, M_FUSE2, M_SIG} mode_t;

  logic [7:0]    code_mem [MEM_DEPTH];
  logic [7:0]    enc_mem  [ENC_DEPTH];
  logic          fuse1, fuse2, ea_lat, prog_q, fire, wr_mode;
  logic [LW-1:0] low_cnt;
  mode_t         mode;

  wire [MEM_AW-1:0] ca = addr[MEM_AW-1:0];
  wire [ENC_AW-1:0] ea = addr[ENC_AW-1:0];

  always_comb begin
    case ({sel_wr, sel_tgt, sel_area, sel_aux})
      4'b1011: mode = M_CODE;
      4'b0011: mode = M_VER;
      4'b1001: mode = M_ENC;
      4'b1111: mode = M_FUSE1;
      4'b1100: mode = M_FUSE2;
      4'b0000: mode = M_SIG;
      default: mode = M_IDLE;
    endcase
  end

  assign wr_mode        = (mode == M_CODE) || (mode == M_ENC) || (mode == M_FUSE1) || (mode == M_FUSE2);
  assign fire           = wr_mode && !prog_q && prog_n && (low_cnt >= LW'(MIN_LOW));
  assign fetch_blocked  = fuse1;
  assign prog_blocked   = fuse1;
  assign verify_blocked = fuse1 && fuse2;
  assign ext_access_eff = fuse1 ? ea_lat : ext_access_n;
  assign pulse_done     = (pulse_cnt == CNT_W'(PULSES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_q  <= 1'b1;
      low_cnt <= '0;
      ea_lat  <= ext_access_n;
    end else begin
      prog_q <= prog_n;
      if (prog_n)
        low_cnt <= '0;
      else if (low_cnt != LW'(MIN_LOW))
        low_cnt <= low_cnt + LW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || erase || !wr_mode)
      pulse_cnt <= '0;
    else if (fire && pulse_cnt != CNT_W'(PULSES))
      pulse_cnt <= pulse_cnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (erase) begin
      fuse1 <= 1'b0;
      fuse2 <= 1'b0;
      for (int i = 0; i < MEM_DEPTH; i++) code_mem[i] <= 8'hFF;
      for (int j = 0; j < ENC_DEPTH; j++) enc_mem[j] <= 8'hFF;
    end else if (rst_n && fire) begin
      case (mode)
        M_CODE:  if (!fuse1) code_mem[ca] <= code_mem[ca] & din;
        M_ENC:   if (!fuse1) enc_mem[ea] <= enc_mem[ea] & din;
        M_FUSE1: fuse1 <= 1'b1;
        M_FUSE2: fuse2 <= 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      vdata <= 8'hFF;
    else begin
      case (mode)
        M_VER: vdata <= verify_blocked ? 8'hFF : ~(code_mem[ca] ^ enc_mem[ea]);
        M_SIG: begin
          if (addr == ADDR_W'(12'h030))      vdata <= 8'h89;
          else if (addr == ADDR_W'(12'h031)) vdata <= SIG_ID;
          else                               vdata <= 8'hFF;
        end
        default: vdata <= 8'hFF;
      endcase
    end
  end
endmodule

module code_lock_ctrl_chk #(
  parameter int ADDR_W = 13,
  parameter int PULSES = 25,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              erase,
  input logic              sel_wr,
  input logic              sel_tgt,
  input logic              sel_area,
  input logic              sel_aux,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        vdata,
  input logic [CNT_W-1:0]  pulse_cnt,
  input logic              prog_blocked,
  input logic              verify_blocked
);
  wire [3:0] pins = {sel_wr, sel_tgt, sel_area, sel_aux};
  wire known = (pins == 4'b1011) || (pins == 4'b0011) || (pins == 4'b1001) ||
               (pins == 4'b1111) || (pins == 4'b1100) || (pins == 4'b0000);

  a_r1_idle_ones: assert property (@(posedge clk) disable iff (!rst_n)
    !known |=> vdata == 8'hFF);
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_cnt <= CNT_W'(PULSES));
  a_r5_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pulse_cnt == $past(pulse_cnt) || pulse_cnt == $past(pulse_cnt) + CNT_W'(1) || pulse_cnt == '0));
  a_r6_fuse_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    prog_blocked && !erase |=> prog_blocked);
  a_r8_needs_fuse1: assert property (@(posedge clk) disable iff (!rst_n)
    verify_blocked |-> prog_blocked);
  a_r8_locked_ones: assert property (@(posedge clk) disable iff (!rst_n)
    verify_blocked && pins == 4'b0011 |=> vdata == 8'hFF);
  a_r9_sig_id: assert property (@(posedge clk) disable iff (!rst_n)
    pins == 4'b0000 && addr == ADDR_W'(12'h030) |=> vdata == 8'h89);
endmodule

bind code_lock_ctrl code_lock_ctrl_chk #(.ADDR_W(ADDR_W), .PULSES(PULSES), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/code_lock_ctrl_bench.sv
module code_lock_ctrl_bench;
  localparam int MINL = 4;
  logic clk = 0, rst_n = 0, erase = 0, prog_n = 1, ext_access_n = 1;
  logic sel_wr = 0, sel_tgt = 0, sel_area = 0, sel_aux = 0;
  logic [12:0] addr = '0;
  logic [7:0]  din = '0, vdata;
  logic [4:0]  pulse_cnt;
  logic pulse_done, fetch_blocked, prog_blocked, verify_blocked, ext_access_eff;
  int total = 0, bad = 0, cycles = 0;

  logic [7:0] code_m [1024];
  logic [7:0] enc_m  [32];
  logic lb1 = 0, lb2 = 0;

  code_lock_ctrl u_code_lock_ctrl (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog expired act=%0d exp=<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_ver(logic [12:0] a);
    return (lb1 && lb2) ? 8'hFF : ~(code_m[a[9:0]] ^ enc_m[a[4:0]]);
  endfunction

  task automatic set_pins(logic [3:0] p);
    {sel_wr, sel_tgt, sel_area, sel_aux} = p;
  endtask

  task automatic do_erase();
    @(negedge clk); erase = 1; @(negedge clk); erase = 0;
    for (int i = 0; i < 1024; i++) code_m[i] = 8'hFF;
    for (int i = 0; i < 32; i++) enc_m[i] = 8'hFF;
    lb1 = 0; lb2 = 0;
  endtask

  task automatic pulse(int w);
    prog_n = 0;
    repeat (w) @(negedge clk);
    prog_n = 1;
    @(negedge clk);
  endtask

  task automatic prog(logic [3:0] p, logic [12:0] a, logic [7:0] d, int w);
    set_pins(p); addr = a; din = d;
    @(negedge clk);
    pulse(w);
    if (w >= MINL) begin
      case (p)
        4'b1011: if (!lb1) code_m[a[9:0]] &= d;
        4'b1001: if (!lb1) enc_m[a[4:0]] &= d;
        4'b1111: lb1 = 1;
        4'b1100: lb2 = 1;
        default: ;
      endcase
    end
  endtask

  task automatic rd(logic [3:0] p, logic [12:0] a);
    set_pins(p); addr = a;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    ext_access_n = 1;
    repeat (2) @(negedge clk);
    do_erase();
    rst_n = 1;
    @(negedge clk);
    chk("R11 vdata after reset", vdata, 8'hFF);
    chk("R11 pulse_cnt after reset", pulse_cnt, 0);
    rd(4'b0011, 13'd77);
    chk("R10 erased verify", vdata, 8'hFF);

    prog(4'b1011, 13'd5, 8'h3C, 4);
    rd(4'b0011, 13'd5);
    chk("R3 raw code with erased table", vdata, 8'h3C);
    prog(4'b1011, 13'd6, 8'h00, 3);
    rd(4'b0011, 13'd6);
    chk("R4 short strobe ignored", vdata, 8'hFF);
    prog(4'b1011, 13'd5, 8'hF0, 6);
    rd(4'b0011, 13'd5);
    chk("R4 AND accumulation", vdata, 8'h30);
    prog(4'b1001, 13'd5, 8'h0F, 4);
    rd(4'b0011, 13'd5);
    chk("R2 scrambled verify", vdata, 8'hC0);
    rd(4'b0011, 13'd37);
    chk("R2 table indexed by low 5 bits", vdata, 8'h0F);

    set_pins(4'b1011); addr = 13'd100; din = 8'hFF;
    @(negedge clk);
    for (int k = 0; k < 3; k++) pulse(4);
    chk("R5 count after 3", pulse_cnt, 3);
    pulse(2);
    chk("R5 short strobe not counted", pulse_cnt, 3);
    for (int k = 0; k < 24; k++) pulse(4);
    chk("R5 saturates", pulse_cnt, 25);
    chk("R5 done flag", pulse_done, 1);
    rd(4'b0011, 13'd100);
    chk("R5 cleared outside write mode", pulse_cnt, 0);

    rd(4'b0101, 13'd5);
    chk("R1 idle pattern reads ones", vdata, 8'hFF);
    prog(4'b1010, 13'd9, 8'h00, 5);
    rd(4'b0011, 13'd9);
    chk("R1 strobe in idle writes nothing", vdata, exp_ver(13'd9));

    rd(4'b0000, 13'h030);
    chk("R9 id byte 0", vdata, 8'h89);
    rd(4'b0000, 13'h031);
    chk("R9 id byte 1", vdata, 8'h52);
    rd(4'b0000, 13'h032);
    chk("R9 other id address", vdata, 8'hFF);

    for (int n = 0; n < 300; n++) begin
      logic [12:0] a;
      int op;
      a = 13'($urandom_range(0, 63));
      op = $urandom_range(0, 3);
      if (op == 0)      prog(4'b1011, a, 8'($urandom), $urandom_range(2, 6));
      else if (op == 1) prog(4'b1001, a, 8'($urandom) | 8'hC3, $urandom_range(2, 6));
      else begin
        rd(4'b0011, a);
        chk("R2 random verify", vdata, exp_ver(a));
      end
    end

    do_erase();
    ext_access_n = 0;
    @(negedge clk);
    chk("R7 strap follows pin unlocked", ext_access_eff, 0);
    prog(4'b1111, 13'd0, 8'h00, 4);
    chk("R6 fetch flag", fetch_blocked, 1);
    chk("R6 prog flag", prog_blocked, 1);
    chk("R8 fuse1 alone keeps verify", verify_blocked, 0);
    chk("R7 strap frozen at reset value", ext_access_eff, 1);
    prog(4'b1011, 13'd12, 8'h00, 5);
    prog(4'b1001, 13'd12, 8'h00, 5);
    rd(4'b0011, 13'd12);
    chk("R6 writes refused", vdata, 8'hFF);
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1;
    ext_access_n = 1;
    @(negedge clk);
    chk("R7 strap re-sampled at reset", ext_access_eff, 0);

    do_erase();
    @(negedge clk);
    chk("R10 fuse cleared", prog_blocked, 0);
    prog(4'b1011, 13'd20, 8'h5A, 4);
    prog(4'b1100, 13'd0, 8'h00, 4);
    chk("R8 fuse2 alone no flag", prog_blocked | verify_blocked, 0);
    rd(4'b0011, 13'd20);
    chk("R8 fuse2 alone verify works", vdata, 8'h5A);
    prog(4'b1111, 13'd0, 8'h00, 4);
    chk("R8 both fuses flag", verify_blocked, 1);
    rd(4'b0011, 13'd20);
    chk("R8 both fuses verify ones", vdata, 8'hFF);
    rd(4'b0000, 13'h031);
    chk("R9 id under fuses", vdata, 8'h52);

    do_erase();
    @(negedge clk);
    chk("R10 unlocked", verify_blocked | fetch_blocked, 0);
    rd(4'b0011, 13'd20);
    chk("R10 code erased", vdata, 8'hFF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule